// File: doc/BRIEF.md
# Condition Flag and Branch Evaluator

This unit keeps the four condition flags of a small processor: zero (Z), negative (N), overflow (V) and carry (C). Each cycle it receives two operands, the result an execution unit produced from them, a width select (byte or word) and an operation class. When the update strobe is high, it derives fresh flags from these and stores them on the next clock edge. The rules are the same for byte and word width; only the bit that serves as sign and the point where carry is taken move.

Alongside the flags, the unit judges a 4-bit branch condition against the stored flags and drives a single taken signal. That check is purely combinational from the flag registers, so a branch issued in the cycle after a flag-setting operation sees that operation's outcome. The unit forms no addresses or targets and decodes no instructions; it is fed by a decoder and an ALU that sit next to it.

Top module: `flag_branch_unit`

## Requirements
- R1: While `rst_n` is low, all four flags are cleared to 0 at the clock edge.
- R2: Operation class 0 (logic): Z is set when the result, masked to the chosen width, is zero; N is the result's sign bit (bit 7 for byte, bit 15 for word); V is cleared; C keeps its previous value.
- R3: Operation class 1 (add): Z and N as in R2; C is set when the unsigned sum of the masked operands exceeds the width's maximum; V is set when both operands have the same sign and the result's sign is different.
- R4: Operation class 2 (subtract): Z and N as in R2; C is set when operand A is below operand B taken as unsigned; V is set when the operand signs differ and the result sign differs from operand A.
- R5: Operation class 3 (compare) sets all four flags exactly as class 2 would for the same inputs.
- R6: Operation class 4 (byte multiply): the result is taken as 16 bits whatever the width select; Z is set when all 16 bits are zero, N is bit 15, and both V and C are cleared.
- R7: Flags change only on a clock edge where `upd_en` is high; with `upd_en` low, or with operation classes 5, 6 or 7, all flags keep their values.
- R8: Condition codes 0 to 7 give: 0 always, 1 never, 2 (C=0 and Z=0), 3 (C=1 or Z=1), 4 C=0, 5 C=1, 6 Z=0, 7 Z=1.
- R9: Condition codes 8 to 13 give: 8 V=0, 9 V=1, 10 N=0, 11 N=1, 12 N equal to V, 13 N unequal to V.
- R10: Condition code 14 is taken when Z=0 and N equals V; code 15 when Z=1 or N differs from V.
- R11: With byte width selected, bits 15..8 of both operands and of the result have no effect on any flag (multiply excepted, R6).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| upd_en | input | 1 | Store new flags at this edge |
| op_cls | input | 3 | Operation class: 0 logic, 1 add, 2 subtract, 3 compare, 4 multiply |
| size_word | input | 1 | 1 selects word (16-bit) width, 0 selects byte |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| res_in | input | 16 | Result produced from the operands |
| cond_code | input | 4 | Branch condition to evaluate |
| flag_z | output | 1 | Stored zero flag |
| flag_n | output | 1 | Stored negative flag |
| flag_v | output | 1 | Stored overflow flag |
| flag_c | output | 1 | Stored carry flag |
| br_taken | output | 1 | Condition holds on the stored flags |

## Verification
The assertions presume the result input belongs to its operands, so that a zero result never carries a set sign bit and a multiply result is a true 16-bit product; the Z/N exclusion check relies on that. The bench keeps within this by computing every result itself from the operands it drives, placing random junk only in the upper byte during byte-width work, where the flags must ignore it. Operation classes 5 to 7 and idle cycles are mixed into the stream so the hold checks see both strobe states.

// File: rtl/fbe_pkg.sv
`timescale 1ns/1ps
package fbe_pkg;
  localparam int COND_W = 4;
  localparam int OPC_W  = 3;

  localparam logic [OPC_W-1:0] OPC_LOGIC = 3'd0;
  localparam logic [OPC_W-1:0] OPC_ADD   = 3'd1;
  localparam logic [OPC_W-1:0] OPC_SUB   = 3'd2;
  localparam logic [OPC_W-1:0] OPC_CMP   = 3'd3;
  localparam logic [OPC_W-1:0] OPC_MUL   = 3'd4;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/fbe_flag_calc.sv
`timescale 1ns/1ps
module fbe_flag_calc
  import fbe_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [OPC_W-1:0]  op_i,
  input  logic              word_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic [WORD_W-1:0] r_i,
  input  flags_t            cur_i,
  output flags_t            nxt_o,
  output logic              known_o
);
  localparam int HALF_W = WORD_W / 2;

  function automatic logic [WORD_W-1:0] fit(input logic [WORD_W-1:0] x, input logic wd);
    return wd ? x : {{(WORD_W-HALF_W){1'b0}}, x[HALF_W-1:0]};
  endfunction

  function automatic logic top_bit(input logic [WORD_W-1:0] x, input logic wd);
    return wd ? x[WORD_W-1] : x[HALF_W-1];
  endfunction

  function automatic logic carry_out(input logic [WORD_W-1:0] x, input logic [WORD_W-1:0] y,
                                     input logic wd);
    logic [WORD_W:0] s;
    s = {1'b0, x} + {1'b0, y};
    return wd ? s[WORD_W] : s[HALF_W];
  endfunction

  // Named internal events
  logic [WORD_W-1:0] a_fit, b_fit, r_fit;
  logic sgn_a, sgn_b, sgn_r;
  logic res_zero, res_neg, wide_zero;
  logic add_c, add_v, sub_c, sub_v;

  assign a_fit     = fit(a_i, word_i);
  assign b_fit     = fit(b_i, word_i);
  assign r_fit     = fit(r_i, word_i);
  assign sgn_a     = top_bit(a_i, word_i);
  assign sgn_b     = top_bit(b_i, word_i);
  assign sgn_r     = top_bit(r_i, word_i);
  assign res_zero  = (r_fit == '0);
  assign res_neg   = sgn_r;
  assign wide_zero = (r_i == '0);
  assign add_c     = carry_out(a_fit, b_fit, word_i);
  assign add_v     = (sgn_a == sgn_b) && (sgn_r != sgn_a);
  assign sub_c     = (a_fit < b_fit);
  assign sub_v     = (sgn_a != sgn_b) && (sgn_r != sgn_a);

  always_comb begin
    nxt_o   = cur_i;
    known_o = 1'b1;
    case (op_i)
      OPC_LOGIC: begin
        nxt_o.z = res_zero;
        nxt_o.n = res_neg;
        nxt_o.v = 1'b0;
      end
      OPC_ADD: begin
        nxt_o.z = res_zero;
        nxt_o.n = res_neg;
        nxt_o.v = add_v;
        nxt_o.c = add_c;
      end
      OPC_SUB, OPC_CMP: begin
        nxt_o.z = res_zero;
        nxt_o.n = res_neg;
        nxt_o.v = sub_v;
        nxt_o.c = sub_c;
      end
      OPC_MUL: begin
        nxt_o.z = wide_zero;
        nxt_o.n = r_i[WORD_W-1];
        nxt_o.v = 1'b0;
        nxt_o.c = 1'b0;
      end
      default: known_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fbe_cond_eval.sv
`timescale 1ns/1ps
module fbe_cond_eval
  import fbe_pkg::*;
(
  input  logic [COND_W-1:0] cc_i,
  input  flags_t            fl_i,
  output logic              take_o
);
  logic n_eq_v;
  assign n_eq_v = (fl_i.n == fl_i.v);

  always_comb begin
    case (cc_i)
      4'h0: take_o = 1'b1;
      4'h1: take_o = 1'b0;
      4'h2: take_o = !fl_i.c && !fl_i.z;
      4'h3: take_o = fl_i.c || fl_i.z;
      4'h4: take_o = !fl_i.c;
      4'h5: take_o = fl_i.c;
      4'h6: take_o = !fl_i.z;
      4'h7: take_o = fl_i.z;
      4'h8: take_o = !fl_i.v;
      4'h9: take_o = fl_i.v;
      4'hA: take_o = !fl_i.n;
      4'hB: take_o = fl_i.n;
      4'hC: take_o = n_eq_v;
      4'hD: take_o = !n_eq_v;
      4'hE: take_o = !fl_i.z && n_eq_v;
      default: take_o = fl_i.z || !n_eq_v;
    endcase
  end
endmodule

// File: rtl/fbe_flag_reg.sv
`timescale 1ns/1ps
module fbe_flag_reg
  import fbe_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   we_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) !rst_n |=> (q_o == '0));
  assert_hold_without_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/flag_branch_unit.sv
`timescale 1ns/1ps
module flag_branch_unit
  import fbe_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [2:0]        op_cls,
  input  logic              size_word,
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  input  logic [WORD_W-1:0] res_in,
  input  logic [3:0]        cond_code,
  output logic              flag_z,
  output logic              flag_n,
  output logic              flag_v,
  output logic              flag_c,
  output logic              br_taken
);
  flags_t cur_flags, nxt_flags;
  logic   op_known, flag_we;

  fbe_flag_calc #(.WORD_W(WORD_W)) calc_i (
    .op_i    (op_cls),
    .word_i  (size_word),
    .a_i     (opnd_a),
    .b_i     (opnd_b),
    .r_i     (res_in),
    .cur_i   (cur_flags),
    .nxt_o   (nxt_flags),
    .known_o (op_known)
  );

  assign flag_we = upd_en && op_known;

  fbe_flag_reg reg_i (
    .clk   (clk),
    .rst_n (rst_n),
    .we_i  (flag_we),
    .d_i   (nxt_flags),
    .q_o   (cur_flags)
  );

  fbe_cond_eval cond_i (
    .cc_i   (cond_code),
    .fl_i   (cur_flags),
    .take_o (br_taken)
  );

  assign flag_z = cur_flags.z;
  assign flag_n = cur_flags.n;
  assign flag_v = cur_flags.v;
  assign flag_c = cur_flags.c;

  assert_logic_clears_v_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_cls == OPC_LOGIC) |=> (!flag_v && flag_c == $past(flag_c)));
  assert_zero_not_negative_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_z && flag_n));
  assert_mul_clears_vc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_cls == OPC_MUL) |=> (!flag_v && !flag_c));
  assert_reserved_class_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cls > OPC_MUL) |=> $stable({flag_z, flag_n, flag_v, flag_c}));
  assert_always_never_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_code == 4'h0 |-> br_taken) and (cond_code == 4'h1 |-> !br_taken));
  assert_signed_gt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_code == 4'hE && br_taken) |-> !flag_z);
endmodule

// File: tb/flag_branch_unit_tb_top.sv
`timescale 1ns/1ps
module flag_branch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_en = 1'b0;
  logic [2:0]  op_cls = 3'd0;
  logic        size_word = 1'b0;
  logic [15:0] opnd_a = '0, opnd_b = '0, res_in = '0;
  logic [3:0]  cond_code = 4'd0;
  logic        flag_z, flag_n, flag_v, flag_c, br_taken;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit mz = 0, mn = 0, mv = 0, mc = 0;

  always #2 clk = ~clk;

  flag_branch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_cls(op_cls), .size_word(size_word),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .res_in(res_in), .cond_code(cond_code),
    .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v), .flag_c(flag_c), .br_taken(br_taken)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic bit want_branch(input logic [3:0] c);
    case (c)
      4'd0:  return 1;
      4'd1:  return 0;
      4'd2:  return (mc | mz) == 0;
      4'd3:  return mc | mz;
      4'd4:  return !mc;
      4'd5:  return mc;
      4'd6:  return !mz;
      4'd7:  return mz;
      4'd8:  return !mv;
      4'd9:  return mv;
      4'd10: return !mn;
      4'd11: return mn;
      4'd12: return !(mn ^ mv);
      4'd13: return mn ^ mv;
      4'd14: return !mz && !(mn ^ mv);
      default: return mz || (mn ^ mv);
    endcase
  endfunction

  function automatic string cond_tag(input logic [3:0] c);
    if (c < 8) return "R8 branch";
    if (c < 14) return "R9 branch";
    return "R10 branch";
  endfunction

  function automatic int as_signed(input int u, input int span);
    return (u >= span / 2) ? u - span : u;
  endfunction

  // Applies one operation, updates the model, checks flags and branch after the edge.
  task automatic apply(input logic [2:0] op, input bit wd, input logic [15:0] a,
                       input logic [15:0] b, input bit en, input logic [3:0] cc,
                       input int lsel);
    int span, ua, ub, ur, sa, sb, sr;
    logic [15:0] rdrv;
    string tag;
    span = wd ? 65536 : 256;
    ua = wd ? int'(a) : int'(a[7:0]);
    ub = wd ? int'(b) : int'(b[7:0]);
    sa = as_signed(ua, span);
    sb = as_signed(ub, span);
    ur = 0;
    case (op)
      3'd0: begin
        case (lsel % 3)
          0: ur = ua & ub;
          1: ur = ua | ub;
          default: ur = ua ^ ub;
        endcase
        tag = "R2";
      end
      3'd1: begin ur = (ua + ub) % span; tag = "R3"; end
      3'd2: begin ur = (ua - ub + span) % span; tag = "R4"; end
      3'd3: begin ur = (ua - ub + span) % span; tag = "R5"; end
      3'd4: begin ur = int'(a[7:0]) * int'(b[7:0]); tag = "R6"; end
      default: begin ur = $urandom % span; tag = "R7 reserved"; end
    endcase
    if (op == 3'd4) rdrv = ur[15:0];
    else if (wd) rdrv = ur[15:0];
    else rdrv = {8'($urandom), ur[7:0]};
    if (!en) tag = "R7 idle";
    else if (!wd && op != 3'd4) tag = {tag, " R11"};

    if (en) begin
      sr = sa;
      case (op)
        3'd0: begin
          mz = (ur == 0); mn = (ur >= span / 2); mv = 0;
        end
        3'd1: begin
          sr = sa + sb;
          mz = (ur == 0); mn = (ur >= span / 2);
          mc = (ua + ub) >= span;
          mv = (sr >= span / 2) || (sr < -(span / 2));
        end
        3'd2, 3'd3: begin
          sr = sa - sb;
          mz = (ur == 0); mn = (ur >= span / 2);
          mc = ua < ub;
          mv = (sr >= span / 2) || (sr < -(span / 2));
        end
        3'd4: begin
          mz = (ur == 0); mn = (ur >= 32768); mv = 0; mc = 0;
        end
        default: ;
      endcase
    end

    @(negedge clk);
    op_cls = op; size_word = wd; opnd_a = a; opnd_b = b; res_in = rdrv;
    upd_en = en; cond_code = cc;
    @(posedge clk);
    #1;
    check(tag, {flag_z, flag_n, flag_v, flag_c}, {mz, mn, mv, mc});
    check(cond_tag(cc), {3'b0, br_taken}, {3'b0, want_branch(cc)});
    @(negedge clk);
    upd_en = 1'b0;
  endtask

  // Holds the flags and walks all sixteen condition codes.
  task automatic sweep_codes();
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      cond_code = 4'(c);
      #1;
      check(cond_tag(4'(c)), {3'b0, br_taken}, {3'b0, want_branch(4'(c))});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    rst_n = 1'b0;
    upd_en = 1'b1; op_cls = 3'd4; opnd_a = 16'h00FF; opnd_b = 16'h00FF; res_in = 16'hFE01;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", {flag_z, flag_n, flag_v, flag_c}, 4'b0000);
    @(negedge clk);
    upd_en = 1'b0;
    rst_n = 1'b1;
    sweep_codes();

    // Corner cases, each followed by a full code sweep
    apply(3'd1, 0, 16'h007F, 16'h0001, 1, 4'hC, 0);  // byte signed overflow
    sweep_codes();
    apply(3'd1, 0, 16'hAB80, 16'h5580, 1, 4'h5, 0);  // byte carry, zero, junk upper
    sweep_codes();
    apply(3'd1, 1, 16'hFFFF, 16'h0001, 1, 4'h3, 0);  // word carry to zero
    sweep_codes();
    apply(3'd2, 1, 16'h8000, 16'h0001, 1, 4'hD, 0);  // word signed overflow
    sweep_codes();
    apply(3'd3, 0, 16'h0000, 16'h0001, 1, 4'hF, 0);  // byte borrow
    sweep_codes();
    apply(3'd0, 1, 16'h8000, 16'hFFFF, 1, 4'hB, 0);  // logic keeps C
    sweep_codes();
    apply(3'd4, 0, 16'h00FF, 16'h00FF, 1, 4'hA, 0);  // multiply, bit 15 set
    sweep_codes();
    apply(3'd4, 1, 16'h1200, 16'h3400, 1, 4'h7, 0);  // multiply to zero
    sweep_codes();
    apply(3'd2, 0, 16'h0040, 16'h0040, 1, 4'hE, 0);  // equal subtract
    sweep_codes();
    apply(3'd6, 1, 16'h0000, 16'h0001, 1, 4'h6, 0);  // reserved class
    apply(3'd1, 1, 16'h7FFF, 16'h7FFF, 0, 4'h9, 0);  // idle cycle

    for (int i = 0; i < 12000; i++) begin
      apply(3'(i % 8), bit'((i / 8) % 2), 16'($urandom), 16'($urandom),
            (i % 11) != 5, 4'($urandom), i / 16);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule